// File: doc/BRIEF.md
# Five-Word Autonomous Code Generator

The block is a free-running synchronous sequencer with no data input. After reset it walks a fixed loop of five 3-bit code words, moving to the next word on every rising clock edge and repeating the loop forever. The next word depends only on the present word.

Each bit of the word is held in its own JK-style flip-flop. A small excitation network computes J and K for each bit from the present word. The network was derived by comparing each bit's present and next value across the five transitions of the loop:

- 0→0 needs J=0.
- 0→1 needs J=1.
- 1→1 needs K=0.
- 1→0 needs K=1.

The three codes that are not in the loop are don't-cares for that derivation. The equations were then checked so that each unused code drains back into the loop.

The named words are:

- CW_IDLE = 000
- CW_RISE = 001
- CW_PAIR = 011
- CW_HIGH = 110
- CW_TAIL = 100

The named transitions are:

- CW_IDLE→CW_RISE
- CW_RISE→CW_PAIR
- CW_PAIR→CW_HIGH
- CW_HIGH→CW_TAIL
- CW_TAIL→CW_IDLE

The recovery transitions are:

- 010→111
- 111→100
- 101→011

The word loaded at reset is a parameter. It defaults to 000.

Top module: `codegen5`

## Requirements
- R1: While `rst_i` is 1 at a rising edge, the output after that edge equals the parameter `RESET_CODE`, whose default is 3'b000. The reset is synchronous and active high.
- R2: Starting from 000 with reset low, the output follows the loop 000, 001, 011, 110, 100, then returns to 000, with one step on each rising edge.
- R3: When the present word is one of the five loop words, every rising edge without reset changes the output. The word never holds.
- R4: From the unused word 010, the next word is 111.
- R5: From the unused word 101, the next word is 011.
- R6: From the unused word 111, the next word is 100.
- R7: From any unused word (010, 101 or 111), the output is a loop word after at most two rising edges. From then on it follows the loop of R2.
- R8: Asserting reset in the middle of the loop returns the output to `RESET_CODE` at the next rising edge, whatever the present word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the word advances on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| code_o | output | 3 | Present code word, bit 2 is the most significant |

## Verification
The unused words 010, 101 and 111 cannot be reached from the ports in normal operation, because the loop never enters them. The bench reaches them by building further copies of the block with `RESET_CODE` set to each unused word. Each copy starts outside the loop right after reset, so its recovery path can be checked step by step, including the two-step path 010→111→100. All copies then run in lockstep against an arithmetic model, across a reset applied in the middle of the loop.

// File: rtl/cg_pkg.sv
package cg_pkg;

    localparam int CODE_W = 3;
    localparam int LOOP_LEN = 5;

    typedef enum logic [CODE_W-1:0] {
        CW_IDLE = 3'b000,
        CW_RISE = 3'b001,
        CW_PAIR = 3'b011,
        CW_HIGH = 3'b110,
        CW_TAIL = 3'b100
    } cw_t;

    // Loop successor written as a plain table, kept apart from the J/K
    // equations so checks against it are independent of them.
    function automatic logic [CODE_W-1:0] cw_successor(input logic [CODE_W-1:0] w);
        logic [CODE_W-1:0] r;
        unique case (w)
            CW_IDLE: r = CW_RISE;
            CW_RISE: r = CW_PAIR;
            CW_PAIR: r = CW_HIGH;
            CW_HIGH: r = CW_TAIL;
            CW_TAIL: r = CW_IDLE;
            default: r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cg_jk_cell.sv
module cg_jk_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic j_i,
    input  logic k_i,
    output logic q_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o <= RST_VAL;
        end else begin
            q_o <= (j_i & ~q_o) | (~k_i & q_o);
        end
    end

    logic armed_q;
    always_ff @(posedge clk_i) begin
        armed_q <= ~rst_i;
    end

    // JK holding and toggling underlie every step of the loop (R2)
    p_jk_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && !$past(j_i) && !$past(k_i)) |-> q_o == $past(q_o));

    p_jk_toggle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(j_i) && $past(k_i)) |-> q_o != $past(q_o));

endmodule

// File: rtl/cg_excite.sv
module cg_excite
    import cg_pkg::*;
(
    input  logic [CODE_W-1:0] q_i,
    output logic [CODE_W-1:0] j_o,
    output logic [CODE_W-1:0] k_o
);

    // Derived per bit from the five loop transitions; unused words are
    // don't-cares and fall back into the loop (R4, R5, R6).
    always_comb begin
        j_o[0] = ~q_i[2];
        k_o[0] =  q_i[1];
        j_o[1] =  q_i[0];
        k_o[1] =  q_i[2];
        j_o[2] =  q_i[1];
        k_o[2] = ~q_i[1];
    end

endmodule

// File: rtl/cg_word_class.sv
module cg_word_class
    import cg_pkg::*;
(
    input  logic [CODE_W-1:0] word_i,
    output cw_t               phase_o,
    output logic              legal_o
);

    always_comb begin
        unique case (word_i)
            CW_IDLE, CW_RISE, CW_PAIR, CW_HIGH, CW_TAIL: begin
                phase_o = cw_t'(word_i);
                legal_o = 1'b1;
            end
            default: begin
                phase_o = CW_IDLE;
                legal_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/codegen5.sv
module codegen5
    import cg_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = 3'b000
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] state_q;
    logic [CODE_W-1:0] j_s;
    logic [CODE_W-1:0] k_s;

    cg_excite u_excite (
        .q_i (state_q),
        .j_o (j_s),
        .k_o (k_s)
    );

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        cg_jk_cell #(
            .RST_VAL (RESET_CODE[b])
        ) u_cell (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .j_i   (j_s[b]),
            .k_i   (k_s[b]),
            .q_o   (state_q[b])
        );
    end

    always_comb begin
        code_o = state_q;
    end

    cw_t  phase_s;
    logic legal_s;

    cg_word_class u_class (
        .word_i  (state_q),
        .phase_o (phase_s),
        .legal_o (legal_s)
    );

    logic       armed_q;
    logic [1:0] stray_run_q;

    always_ff @(posedge clk_i) begin
        armed_q <= ~rst_i;
        if (rst_i) begin
            stray_run_q <= 2'd0;
        end else if (legal_s) begin
            stray_run_q <= 2'd0;
        end else if (stray_run_q != 2'd3) begin
            stray_run_q <= stray_run_q + 2'd1;
        end
    end

    p_reset_load_r1: assert property (@(posedge clk_i)
        rst_i |=> code_o == RESET_CODE);

    p_loop_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(legal_s)) |-> code_o == cw_successor($past(phase_s)));

    p_always_moves_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(legal_s)) |-> code_o != $past(code_o));

    p_stray_010_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(code_o) == 3'b010) |-> code_o == 3'b111);

    p_stray_101_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(code_o) == 3'b101) |-> code_o == 3'b011);

    p_stray_111_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(code_o) == 3'b111) |-> code_o == 3'b100);

    p_recover_bound_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        stray_run_q != 2'd3);

endmodule

// File: tb/codegen5_bench.sv
module codegen5_bench;

    localparam int NI = 4;
    localparam logic [2:0] LOOP [5] = '{3'b000, 3'b001, 3'b011, 3'b110, 3'b100};
    localparam logic [2:0] SEED [NI] = '{3'b000, 3'b010, 3'b101, 3'b111};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] outs [NI];

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    codegen5 u_codegen5 (.clk_i(clk), .rst_i(rst), .code_o(outs[0]));
    codegen5 #(.RESET_CODE(3'b010)) u_seed_010 (.clk_i(clk), .rst_i(rst), .code_o(outs[1]));
    codegen5 #(.RESET_CODE(3'b101)) u_seed_101 (.clk_i(clk), .rst_i(rst), .code_o(outs[2]));
    codegen5 #(.RESET_CODE(3'b111)) u_seed_111 (.clk_i(clk), .rst_i(rst), .code_o(outs[3]));

    function automatic bit in_loop(input logic [2:0] w);
        for (int i = 0; i < 5; i++) if (LOOP[i] == w) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [2:0] model_next(input logic [2:0] w);
        if (w == 3'b010) return 3'b111;
        if (w == 3'b101) return 3'b011;
        if (w == 3'b111) return 3'b100;
        for (int i = 0; i < 5; i++) if (LOOP[i] == w) return LOOP[(i + 1) % 5];
        return 3'bxxx;
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic run_steps(input int n, inout logic [2:0] m [NI], inout int stray [NI]);
        for (int s = 0; s < n; s++) begin
            logic [2:0] prev [NI];
            @(posedge clk);
            @(negedge clk);
            for (int i = 0; i < NI; i++) begin
                prev[i] = m[i];
                m[i] = model_next(m[i]);
                if (prev[i] == 3'b010)      chk("R4", outs[i], m[i]);
                else if (prev[i] == 3'b101) chk("R5", outs[i], m[i]);
                else if (prev[i] == 3'b111) chk("R6", outs[i], m[i]);
                else                        chk("R2", outs[i], m[i]);
                if (!in_loop(prev[i])) stray[i]++;
                if (stray[i] == 2 && !in_loop(prev[i]))
                    chk("R7", {2'b00, in_loop(outs[i])}, 3'b001);
            end
            if (in_loop(prev[0]))
                chk("R3", {2'b00, outs[0] != prev[0]}, 3'b001);
        end
    endtask

    initial begin
        logic [2:0] m [NI];
        int stray [NI];
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            chk("R1", outs[i], SEED[i]);
            m[i] = SEED[i];
            stray[i] = 0;
        end
        rst = 1'b0;
        run_steps(17, m, stray);   // over three full loops
        // mid-loop reset: default copy now sits at 011 (R8)
        chk("R8", outs[0], 3'b011);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            chk("R8", outs[i], SEED[i]);
            m[i] = SEED[i];
            stray[i] = 0;
        end
        rst = 1'b0;
        run_steps(12, m, stray);
        finish_run();
    end

endmodule